// File: doc/BRIEF.md
# Aligned Pipelined Four-Operand Multiplier

This block multiplies four independent unsigned operands (`data`, `a`, `b`, `c`) and returns the full-width product. It is fully pipelined. A new operand set, unrelated to the one before it, may be presented on every clock edge. One result leaves the block per cycle.

The key property is alignment. Each pipeline stage takes its terms only from registers of the stage just before it. Those registers hold either a computed partial product or a delayed copy of an operand. Because of this, a late stage never combines a partial product with an operand from a newer set.

A parameter picks one of two structures:
- **Serial chain.** Three stages. The operands `b` and `c` are carried forward through one and two copy registers.
- **Balanced tree.** Two stages. The first stage forms two pairwise products side by side, and the second stage multiplies them.

A valid bit travels alongside the data. It is delayed by exactly the latency of the selected structure and marks the cycle on which the output belongs to an input set.

Top module: `quad_mul_pipe`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `valid_o` is 0 and `prod_o` is 0.
- R2: With `ARCH = ARCH_CHAIN`, an operand set captured on clock edge k appears on `prod_o` after edge k+2, that is three edges after capture. The output value is `data_i*a_i*b_i*c_i`.
- R3: With `ARCH = ARCH_TREE`, an operand set captured on clock edge k appears on `prod_o` after edge k+1, that is two edges after capture. The output value is `data_i*a_i*b_i*c_i`.
- R4: When different operand sets arrive on consecutive edges, each output product uses only the operands of its own set. In chain mode, the copies of `b` and `c` that are used lag the inputs by one and two cycles respectively.
- R5: `valid_o` equals `valid_i` delayed by the selected latency (3 for chain, 2 for tree). An input bubble gives an output bubble in the matching cycle.
- R6: `prod_o` is 4*W bits wide and exact for all operand values. With W=8 and all operands at 255, the output is 0xFC05FC01.
- R7: If any operand of a set is 0, the matching output product is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Marks the current operand set as valid |
| data_i | input | W | Operand data |
| a_i | input | W | Operand a |
| b_i | input | W | Operand b |
| c_i | input | W | Operand c |
| valid_o | output | 1 | Marks `prod_o` as the result of a valid set |
| prod_o | output | 4*W | Product of the four operands |

## Verification
The assertions assume the following about the inputs:
- They are driven to known values on every cycle after reset release.
- `valid_i` is held low during reset, so the delayed-input comparisons only start once enough cycles have passed since release to fill the selected latency.

The bench keeps within these assumptions:
- It holds every input at zero throughout reset.
- It then changes all four operands on every cycle, so operand mixing cannot hide behind stable inputs.
- It mixes in directed sets (all operands at the maximum value, a zero in one operand, and valid bubbles) and drives both structures from the same stimulus.

// File: rtl/quad_mul_pkg.sv
package quad_mul_pkg;
  typedef enum logic {ARCH_CHAIN = 1'b0, ARCH_TREE = 1'b1} arch_e;

  function automatic int arch_latency(arch_e arch);
    return (arch == ARCH_TREE) ? 2 : 3;
  endfunction
endpackage

// File: rtl/qm_mul_stage.sv
// Registered unsigned multiplier, full-width result.
module qm_mul_stage #(
  parameter int WA = 8,
  parameter int WB = 8,
  localparam int WP = WA + WB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WA-1:0] x_i,
  input  logic [WB-1:0] y_i,
  output logic [WP-1:0] p_o
);
  logic [WP-1:0] x_ext, y_ext;

  assign x_ext = {{WB{1'b0}}, x_i};
  assign y_ext = {{WA{1'b0}}, y_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_o <= '0;
    else         p_o <= x_ext * y_ext;
  end
endmodule

// File: rtl/qm_pipe_reg.sv
// Fixed-depth delay line used for operand copies and the valid bit.
module qm_pipe_reg #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/quad_mul_pipe.sv
module quad_mul_pipe
  import quad_mul_pkg::*;
#(
  parameter int    W    = 8,
  parameter arch_e ARCH = ARCH_CHAIN,
  localparam int   PW   = 4 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [W-1:0]  data_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  c_i,
  output logic          valid_o,
  output logic [PW-1:0] prod_o
);
  localparam int       LAT  = arch_latency(ARCH);
  localparam bit [2:0] LAT3 = 3'(LAT);

  logic [PW-1:0] prod_w;

  if (ARCH == ARCH_CHAIN) begin : g_chain
    logic [2*W-1:0] s1_w;
    logic [3*W-1:0] s2_w;
    logic [W-1:0]   b_cp1, c_cp2;

    // stage 1: data*a, copy b once, c enters its two-deep copy line
    qm_mul_stage #(.WA(W), .WB(W)) u_s1 (
      .clk_i(clk_i), .rst_ni(rst_ni), .x_i(data_i), .y_i(a_i), .p_o(s1_w));
    qm_pipe_reg #(.WIDTH(W), .DEPTH(1)) u_bcp (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(b_i), .q_o(b_cp1));
    qm_pipe_reg #(.WIDTH(W), .DEPTH(2)) u_ccp (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(c_i), .q_o(c_cp2));
    // stage 2: partial * copied b
    qm_mul_stage #(.WA(2*W), .WB(W)) u_s2 (
      .clk_i(clk_i), .rst_ni(rst_ni), .x_i(s1_w), .y_i(b_cp1), .p_o(s2_w));
    // stage 3: partial * twice-copied c
    qm_mul_stage #(.WA(3*W), .WB(W)) u_s3 (
      .clk_i(clk_i), .rst_ni(rst_ni), .x_i(s2_w), .y_i(c_cp2), .p_o(prod_w));
  end else begin : g_tree
    logic [2*W-1:0] pa_w, pb_w;

    // stage 1: two pair products in parallel
    qm_mul_stage #(.WA(W), .WB(W)) u_pa (
      .clk_i(clk_i), .rst_ni(rst_ni), .x_i(a_i), .y_i(data_i), .p_o(pa_w));
    qm_mul_stage #(.WA(W), .WB(W)) u_pb (
      .clk_i(clk_i), .rst_ni(rst_ni), .x_i(b_i), .y_i(c_i), .p_o(pb_w));
    // stage 2: combine pairs
    qm_mul_stage #(.WA(2*W), .WB(2*W)) u_s2 (
      .clk_i(clk_i), .rst_ni(rst_ni), .x_i(pa_w), .y_i(pb_w), .p_o(prod_w));
  end

  qm_pipe_reg #(.WIDTH(1), .DEPTH(LAT)) u_vld (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(valid_i), .q_o(valid_o));

  assign prod_o = prod_w;

  // ---------------- assertions ----------------
  logic [2:0] cyc_q;  // cycles since reset release, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 3'd7)   cyc_q <= cyc_q + 3'd1;
  end

  function automatic logic [PW-1:0] ref_prod(logic [W-1:0] d, logic [W-1:0] a,
                                             logic [W-1:0] b, logic [W-1:0] c);
    logic [PW-1:0] r;
    r = PW'(d) * PW'(a);
    r = r * PW'(b);
    r = r * PW'(c);
    return r;
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 3'd0) |-> (!valid_o && prod_o == '0));

  // R5
  valid_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= LAT3) |-> (valid_o == $past(valid_i, LAT)));

  // R2 R3 R6
  prod_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= LAT3) |-> (prod_o == $past(ref_prod(data_i, a_i, b_i, c_i), LAT)));

  // R7
  zero_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc_q >= LAT3) && ($past(data_i, LAT) == '0 || $past(c_i, LAT) == '0))
      |-> (prod_o == '0));

  if (ARCH == ARCH_CHAIN) begin : g_chain_chk
    // R4
    b_copy_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q >= 3'd1) |-> (g_chain.b_cp1 == $past(b_i)));
    // R4
    c_copy_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q >= 3'd2) |-> (g_chain.c_cp2 == $past(c_i, 2)));
  end
endmodule

// File: tb/quad_mul_pipe_tb.sv
module quad_mul_pipe_tb;
  import quad_mul_pkg::*;

  localparam int W  = 8;
  localparam int PW = 4 * W;
  localparam int N  = 300;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  data_i = '0, a_i = '0, b_i = '0, c_i = '0;
  logic          vld_ch, vld_tr;
  logic [PW-1:0] prod_ch, prod_tr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0]  s_d [N], s_a [N], s_b [N], s_c [N];
  logic          s_v [N];
  logic [PW-1:0] s_p [N];
  string         s_tag [N];

  always #2.5 clk = ~clk;

  quad_mul_pipe #(.W(W), .ARCH(ARCH_CHAIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .valid_o(vld_ch), .prod_o(prod_ch));

  quad_mul_pipe #(.W(W), .ARCH(ARCH_TREE)) u_dut_tree (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .valid_o(vld_tr), .prod_o(prod_tr));

  function automatic logic [PW-1:0] exp_prod(logic [W-1:0] d, logic [W-1:0] a,
                                             logic [W-1:0] b, logic [W-1:0] c);
    longint unsigned r;
    r = longint'(d) * longint'(a) * longint'(b) * longint'(c);
    return r[PW-1:0];
  endfunction

  task automatic chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_out(int t, int lat, logic vld, logic [PW-1:0] prod, string mode);
    int j;
    j = t - lat;
    if (j < 0) begin
      chk({"R5 ", mode, " idle valid"}, PW'(vld), '0);
    end else if (j < N) begin
      chk({"R5 ", mode, " valid"}, PW'(vld), PW'(s_v[j]));
      if (s_v[j]) chk({s_tag[j], " ", mode, " product"}, prod, s_p[j]);
    end else begin
      chk({"R5 ", mode, " drain valid"}, PW'(vld), '0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    for (int j = 0; j < N; j++) begin
      s_d[j] = W'($urandom); s_a[j] = W'($urandom);
      s_b[j] = W'($urandom); s_c[j] = W'($urandom);
      s_v[j] = ($urandom % 10) != 0;
      s_tag[j] = "R4";
    end
    // directed corners
    s_d[0] = '1; s_a[0] = '1; s_b[0] = '1; s_c[0] = '1; s_v[0] = 1'b1; s_tag[0] = "R6";
    s_d[1] = '0; s_v[1] = 1'b1; s_tag[1] = "R7";
    s_c[2] = '0; s_v[2] = 1'b1; s_tag[2] = "R7";
    s_v[3] = 1'b0; s_v[4] = 1'b0;
    s_d[5] = '1; s_a[5] = 8'd1; s_b[5] = 8'd1; s_c[5] = 8'd1; s_v[5] = 1'b1; s_tag[5] = "R6";
    s_a[6] = '0; s_v[6] = 1'b1; s_tag[6] = "R7";
    for (int j = 0; j < N; j++) s_p[j] = exp_prod(s_d[j], s_a[j], s_b[j], s_c[j]);

    // R1: outputs clear in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 chain valid", PW'(vld_ch), '0);
    chk("R1 chain prod", prod_ch, '0);
    chk("R1 tree valid", PW'(vld_tr), '0);
    chk("R1 tree prod", prod_tr, '0);
    chk("R6 max constant", s_p[0], 32'hFC05FC01);
    rst_ni = 1'b1;

    for (int t = 0; t < N + 4; t++) begin
      @(negedge clk);
      // R2 chain latency 3, R3 tree latency 2
      check_out(t, 3, vld_ch, prod_ch, "R2 chain");
      check_out(t, 2, vld_tr, prod_tr, "R3 tree");
      if (t < N) begin
        valid_i = s_v[t]; data_i = s_d[t]; a_i = s_a[t]; b_i = s_b[t]; c_i = s_c[t];
      end else begin
        valid_i = 1'b0; data_i = W'($urandom); a_i = W'($urandom);
        b_i = W'($urandom); c_i = W'($urandom);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule